// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Decoder

This block is the bus-facing slave controller of a digitally controlled potentiometer. It watches a two-wire serial bus (clock and open-drain data), oversampled on the system clock. It finds start and stop conditions, matches an identification byte against a fixed type code and three address pins, and decodes a command byte. It then hands one-cycle command strobes, a register pointer, a bank number and write data to the register logic that sits beside it. On reads it shifts the register logic's data back onto the bus.

A command byte carries a 4-bit opcode in its upper nibble, a data-register index in bits 3:2 and a bank number in bits 1:0. There are three kinds of command. Transfers between a data register and the wiper end after the command byte. Reads and writes carry one more data byte. The step command opens a stream in which every clock pulse moves the wiper by one position, until a stop arrives.

The data output is a pull-low request. The pad, or the bench, forms the wired-AND of it with the master's drive.

Top module: `tw_pot_decoder`

## Requirements
- R1: A start (data falling while clock is high) restarts identification matching from any state, including in the middle of a byte. A stop (data rising while clock is high) returns the block to idle. Clock pulses that arrive after a stop and before the next start produce no acknowledge, no strobe and no step.
- R2: The identification byte, sent MSB first, is acknowledged only if bits 7:4 equal 0101, bit 3 is 0, and bits 2:0 equal `dev_addr_i`. On a mismatch the block acknowledges nothing else until the next start.
- R3: The opcode in command bits 7:4 is decoded, and valid commands are acknowledged. `cmd_o` is encoded as 1 read wiper (1001), 2 write wiper (1010), 3 read register (1011), 4 write register (1100), 5 register to wiper (1101), 6 wiper to register (1110) and 7 step (0010). `cmd_stb_o` is only ever raised with a nonzero `cmd_o`.
- R4: A command other than register read or register write is invalid when bank bits 1:0 are nonzero. An invalid command gets no acknowledge and no strobe.
- R5: Any other opcode gets no acknowledge and no strobe. The rest of that transfer is ignored, including the acknowledge of any following byte.
- R6: Every accepted command gives exactly one `cmd_stb_o` pulse, one cycle long. `reg_sel_o` carries command bits 3:2 and `bank_o` carries command bits 1:0. For transfers, reads and step, the pulse follows the falling clock edge that ends the command byte.
- R7: For write commands the data byte is acknowledged. The strobe follows the falling clock edge that ends the data byte, with that byte on `wdata_o`.
- R8: For read commands, `rdata_i` is captured at the end of the command acknowledge and driven MSB first, each bit changed after a falling clock edge. The data line is released for the master's acknowledge.
- R9: After a step command, every complete clock pulse gives one `step_stb_o` pulse, issued after the falling clock edge. `step_up_o` is 1 when data was high at the rising edge and 0 when it was low. A pulse cut short by a stop or a start gives no step. `step_stb_o` is never raised together with `cmd_stb_o`, and only while `cmd_o` is 7.
- R10: `sda_pull_o` begins pulling only after a falling clock edge, never while the clock is high.
- R11: After reset the data line is released and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND result) |
| dev_addr_i | input | 3 | Address pins matched against identification bits 2:0 |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 3 | Decoded command code |
| reg_sel_o | output | 2 | Data register index |
| bank_o | output | 2 | Register bank |
| wdata_o | output | 8 | Data byte of a write command |
| rdata_i | input | 8 | Read data from the register logic |
| step_stb_o | output | 1 | One-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
Each bus edge passes two synchronizer flops and one edge-detect flop. Every registered result (acknowledge pull, command strobe, step strobe, read bit) therefore appears three to four system cycles after the bus line changes. The bench holds each bus phase for ten cycles and samples the data line in the middle of the clock-high phase, well after that latency. Strobes are collected by a falling-clock monitor and compared after the stop, so a strobe due on the last byte is always in the log when it is checked.

// File: rtl/tw_pot_pkg.sv
package tw_pot_pkg;

   localparam int BYTE_W  = 8;
   localparam int NUM_OPC = 7;

   typedef enum logic [2:0] {
      CMD_NONE         = 3'd0,
      CMD_RD_WIPER     = 3'd1,
      CMD_WR_WIPER     = 3'd2,
      CMD_RD_REG       = 3'd3,
      CMD_WR_REG       = 3'd4,
      CMD_REG_TO_WIPER = 3'd5,
      CMD_WIPER_TO_REG = 3'd6,
      CMD_STEP         = 3'd7
   } cmd_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ID,
      PH_INSTR,
      PH_WDATA,
      PH_RDATA,
      PH_STEP,
      PH_HOLD
   } phase_e;

endpackage

// File: rtl/tw_pot_sync.sv
module tw_pot_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("tw_pot_sync needs at least two stages");
      end
   endgenerate

   // Idle bus lines are high, so the chain resets high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~last_q;
   assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/tw_pot_decode.sv
module tw_pot_decode
   import tw_pot_pkg::*;
(
   input  logic [BYTE_W-1:0] instr_i,
   output cmd_e              cmd_o,
   output logic              valid_o
);

   // Entry i holds the opcode whose command code is i+1.
   localparam logic [4*NUM_OPC-1:0] OPC_TABLE =
      {4'h2, 4'hE, 4'hD, 4'hC, 4'hB, 4'hA, 4'h9};

   logic [NUM_OPC-1:0] hit;
   logic               any_bank;

   generate
      for (genvar i = 0; i < NUM_OPC; i++) begin : g_opc
         assign hit[i] = (instr_i[7:4] == OPC_TABLE[4*i +: 4]);
      end
   endgenerate

   always_comb begin
      cmd_o = CMD_NONE;
      for (int i = 0; i < NUM_OPC; i++) begin
         if (hit[i]) cmd_o = cmd_e'(3'(i + 1));
      end
   end

   // Only plain register reads and writes may address banks 1..3.
   assign any_bank = (cmd_o == CMD_RD_REG) || (cmd_o == CMD_WR_REG);
   assign valid_o  = (cmd_o != CMD_NONE) && (any_bank || (instr_i[1:0] == 2'b00));

endmodule

// File: rtl/tw_pot_decoder.sv
module tw_pot_decoder
   import tw_pot_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] dev_addr_i,
   output logic       sda_pull_o,
   output logic       cmd_stb_o,
   output logic [2:0] cmd_o,
   output logic [1:0] reg_sel_o,
   output logic [1:0] bank_o,
   output logic [7:0] wdata_o,
   input  logic [7:0] rdata_i,
   output logic       step_stb_o,
   output logic       step_up_o
);

   localparam int CNT_W   = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;
   logic start_ev, stop_ev;

   tw_pot_sync #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i),
      .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   tw_pot_sync #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i),
      .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   assign start_ev = sda_fall & scl_s;
   assign stop_ev  = sda_rise & scl_s;

   phase_e            phase_q, next_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_q, tx_q, wdata_q;
   logic              pull_q, stb_q, step_stb_q, step_up_q;
   logic              pend_q, pend_dir_q;
   cmd_e              cmd_q;
   logic [1:0]        reg_q, bank_q;

   cmd_e dec_cmd;
   logic dec_valid;
   logic id_match;

   tw_pot_decode u_dec (
      .instr_i(rx_q),
      .cmd_o  (dec_cmd),
      .valid_o(dec_valid)
   );

   assign id_match = (rx_q[7:4] == TYPE_CODE) && !rx_q[3] && (rx_q[2:0] == dev_addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         next_q     <= PH_IDLE;
         cnt_q      <= '0;
         rx_q       <= '0;
         tx_q       <= '0;
         wdata_q    <= '0;
         pull_q     <= 1'b0;
         stb_q      <= 1'b0;
         step_stb_q <= 1'b0;
         step_up_q  <= 1'b0;
         pend_q     <= 1'b0;
         pend_dir_q <= 1'b0;
         cmd_q      <= CMD_NONE;
         reg_q      <= '0;
         bank_q     <= '0;
      end else begin
         stb_q      <= 1'b0;
         step_stb_q <= 1'b0;
         if (start_ev) begin
            phase_q <= PH_ID;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
            pend_q  <= 1'b0;
         end else if (stop_ev) begin
            phase_q <= PH_IDLE;
            pull_q  <= 1'b0;
            pend_q  <= 1'b0;
         end else begin
            case (phase_q)
               PH_IDLE, PH_HOLD: ;
               PH_STEP: begin
                  // A pulse counts only once its falling edge arrives.
                  if (scl_rise) begin
                     pend_q     <= 1'b1;
                     pend_dir_q <= sda_s;
                  end
                  if (scl_fall && pend_q) begin
                     step_stb_q <= 1'b1;
                     step_up_q  <= pend_dir_q;
                     pend_q     <= 1'b0;
                  end
               end
               default: begin
                  if (scl_rise) begin
                     if (cnt_q < CNT_FULL) begin
                        rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                     end else if (cnt_q == CNT_FULL) begin
                        cnt_q <= CNT_ACK;
                     end
                  end
                  if (scl_fall) begin
                     if (phase_q == PH_RDATA && cnt_q != '0 && cnt_q < CNT_FULL) begin
                        tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        pull_q <= ~tx_q[BYTE_W-2];
                     end else if (cnt_q == CNT_FULL) begin
                        case (phase_q)
                           PH_ID: begin
                              if (id_match) begin
                                 pull_q <= 1'b1;
                                 next_q <= PH_INSTR;
                              end else begin
                                 phase_q <= PH_HOLD;
                              end
                           end
                           PH_INSTR: begin
                              if (dec_valid) begin
                                 pull_q <= 1'b1;
                                 cmd_q  <= dec_cmd;
                                 reg_q  <= rx_q[3:2];
                                 bank_q <= rx_q[1:0];
                                 case (dec_cmd)
                                    CMD_WR_WIPER, CMD_WR_REG: next_q <= PH_WDATA;
                                    CMD_RD_WIPER, CMD_RD_REG: begin
                                       next_q <= PH_RDATA;
                                       stb_q  <= 1'b1;
                                    end
                                    CMD_STEP: begin
                                       next_q <= PH_STEP;
                                       stb_q  <= 1'b1;
                                    end
                                    default: begin
                                       next_q <= PH_HOLD;
                                       stb_q  <= 1'b1;
                                    end
                                 endcase
                              end else begin
                                 phase_q <= PH_HOLD;
                              end
                           end
                           PH_WDATA: begin
                              pull_q  <= 1'b1;
                              wdata_q <= rx_q;
                              stb_q   <= 1'b1;
                              next_q  <= PH_HOLD;
                           end
                           default: begin
                              // Read byte done: leave the line to the master.
                              pull_q <= 1'b0;
                              next_q <= PH_HOLD;
                           end
                        endcase
                     end else if (cnt_q == CNT_ACK) begin
                        cnt_q   <= '0;
                        phase_q <= next_q;
                        if (next_q == PH_RDATA) begin
                           tx_q   <= rdata_i;
                           pull_q <= ~rdata_i[BYTE_W-1];
                        end else begin
                           pull_q <= 1'b0;
                        end
                     end
                  end
               end
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign cmd_stb_o  = stb_q;
   assign cmd_o      = cmd_q;
   assign reg_sel_o  = reg_q;
   assign bank_o     = bank_q;
   assign wdata_o    = wdata_q;
   assign step_stb_o = step_stb_q;
   assign step_up_o  = step_up_q;

endmodule

// File: rtl/tw_pot_decoder_chk.sv
module tw_pot_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_pull_o,
   input logic       cmd_stb_o,
   input logic [2:0] cmd_o,
   input logic [1:0] bank_o,
   input logic       step_stb_o
);

   assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !$past(scl_s));

   assert_strobe_has_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |-> (cmd_o != 3'd0));

   assert_wiper_bank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o && cmd_o != 3'd3 && cmd_o != 3'd4) |-> (bank_o == 2'd0));

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);

   assert_step_not_with_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_stb_o && cmd_stb_o));

   assert_step_in_step_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_stb_o |-> (cmd_o == 3'd7));

endmodule

bind tw_pot_decoder tw_pot_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .sda_pull_o(sda_pull_o),
   .cmd_stb_o (cmd_stb_o),
   .cmd_o     (cmd_o),
   .bank_o    (bank_o),
   .step_stb_o(step_stb_o)
);

// File: tb/sim_tw_pot_decoder.sv
module sim_tw_pot_decoder;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] pins = 3'b101;
   logic [7:0] rd_val = 8'h00;
   logic       sda_pull_o, cmd_stb_o, step_stb_o, step_up_o;
   logic [2:0] cmd_o;
   logic [1:0] reg_sel_o, bank_o;
   logic [7:0] wdata_o;
   wire        sda_bus = sda_m & ~sda_pull_o;

   int ntot = 0, nbad = 0;
   int n_stb = 0, n_step = 0, n_up = 0, n_r10 = 0;
   logic [2:0] l_cmd = '0;
   logic [1:0] l_reg = '0, l_bank = '0;
   logic [7:0] l_wd = '0;
   logic       pull_prev = 1'b0;

   always #5 clk = ~clk;

   tw_pot_decoder u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .dev_addr_i(pins), .sda_pull_o(sda_pull_o), .cmd_stb_o(cmd_stb_o),
      .cmd_o(cmd_o), .reg_sel_o(reg_sel_o), .bank_o(bank_o),
      .wdata_o(wdata_o), .rdata_i(rd_val), .step_stb_o(step_stb_o),
      .step_up_o(step_up_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_stb_o) begin
            n_stb++;
            l_cmd  = cmd_o;
            l_reg  = reg_sel_o;
            l_bank = bank_o;
            l_wd   = wdata_o;
         end
         if (step_stb_o) begin
            n_step++;
            if (step_up_o) n_up++;
         end
         if (sda_pull_o && !pull_prev && scl) n_r10++;
         pull_prev = sda_pull_o;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      ntot++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic bit_io(input logic b, output logic s);
      sda_m = b; wq(); scl = 1'b1; wq(); s = sda_bus; wq(); scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_io(v[i], s);
      bit_io(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, s);
         d[i] = s;
      end
      bit_io(1'b0, s);
   endtask

   // Expected command code from the requirement table, 0 when refused.
   function automatic int ref_code(input logic [7:0] ins);
      int c;
      case (ins[7:4])
         4'h9: c = 1;
         4'hA: c = 2;
         4'hB: c = 3;
         4'hC: c = 4;
         4'hD: c = 5;
         4'hE: c = 6;
         4'h2: c = 7;
         default: c = 0;
      endcase
      if (c != 0 && c != 3 && c != 4 && ins[1:0] != 2'b00) c = 0;
      return c;
   endfunction

   function automatic int ones(input logic [31:0] v, input int n);
      int k = 0;
      for (int i = 0; i < n; i++) if (v[i]) k++;
      return k;
   endfunction

   task automatic do_xact(input logic [7:0] idb, input logic [7:0] ins,
                          input logic [7:0] dat, input int nsteps,
                          input logic [31:0] sbits);
      logic       ack, s, id_ok, iack;
      logic [7:0] d;
      int         code, s0, st0, up0;
      code = ref_code(ins);
      id_ok = (idb == {4'b0101, 1'b0, pins});
      iack = id_ok && (code != 0);
      s0 = n_stb; st0 = n_step; up0 = n_up;
      bus_start();
      send_byte(idb, ack);
      chk("R2 id acknowledge", int'(ack), int'(id_ok));
      send_byte(ins, ack);
      chk("R3 R4 R5 command acknowledge", int'(ack), int'(iack));
      if (iack) begin
         if (code == 2 || code == 4) begin
            send_byte(dat, ack);
            chk("R7 data acknowledge", int'(ack), 1);
         end else if (code == 1 || code == 3) begin
            recv_byte(d);
            chk("R8 read data", int'(d), int'(rd_val));
         end else if (code == 7) begin
            for (int k = 0; k < nsteps; k++) bit_io(sbits[k], s);
         end
      end else begin
         send_byte(dat, ack);
         chk("R2 R5 ignored byte not acknowledged", int'(ack), 0);
      end
      bus_stop();
      wq();
      chk("R6 strobe count", n_stb - s0, iack ? 1 : 0);
      if (iack) begin
         chk("R3 command code", int'(l_cmd), code);
         chk("R6 register index", int'(l_reg), int'(ins[3:2]));
         chk("R6 bank", int'(l_bank), int'(ins[1:0]));
         if (code == 2 || code == 4) chk("R7 write data", int'(l_wd), int'(dat));
      end
      chk("R9 step count", n_step - st0, (iack && code == 7) ? nsteps : 0);
      chk("R9 up steps", n_up - up0, (iack && code == 7) ? ones(sbits, nsteps) : 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      ntot++; nbad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

   localparam logic [7:0] OPS [8] = '{8'h90, 8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0, 8'h20, 8'h50};

   initial begin
      logic s;
      int   sn;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      chk("R11 reset pull", int'(sda_pull_o), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R11 released after reset", int'(sda_pull_o), 0);
      chk("R11 no strobe after reset", n_stb + n_step, 0);

      // Directed cases.
      do_xact(8'h55, 8'hA0, 8'hA5, 0, 0);            // write wiper
      do_xact(8'h54, 8'hC4, 8'h11, 0, 0);            // wrong address
      do_xact(8'h75, 8'hA0, 8'h11, 0, 0);            // wrong type code
      do_xact(8'h5D, 8'hA0, 8'h11, 0, 0);            // bit 3 set
      rd_val = 8'h3C;
      do_xact(8'h55, 8'hB6, 8'h00, 0, 0);            // read register, bank 2
      do_xact(8'h55, 8'hD1, 8'h00, 0, 0);            // R4 wiper cmd bank 1
      do_xact(8'h55, 8'h00, 8'h00, 0, 0);            // R5 bad opcode
      do_xact(8'h55, 8'hE8, 8'h00, 0, 0);            // wiper to register 2
      rd_val = 8'hC3;
      do_xact(8'h55, 8'h90, 8'h00, 0, 0);            // read wiper
      do_xact(8'h55, 8'h20, 8'h00, 8, 32'h0000_001F); // five up, three down

      // R1: bus clocks after a stop give nothing.
      sn = n_stb + n_step;
      for (int k = 0; k < 9; k++) begin
         bit_io(1'b1, s);
         chk("R1 no acknowledge after stop", int'(s), 1);
      end
      chk("R1 no strobe after stop", n_stb + n_step - sn, 0);
      sda_m = 1'b1; wq(); scl = 1'b1; wq();

      // R1: start in the middle of an ID byte restarts matching.
      bus_start();
      for (int k = 0; k < 4; k++) bit_io(k[0], s);
      do_xact(8'h55, 8'hC3, 8'h5A, 0, 0);

      // Random traffic.
      for (int it = 0; it < 40; it++) begin
         logic [7:0] idb, ins;
         logic [31:0] sb;
         pins   = 3'($urandom);
         rd_val = 8'($urandom);
         idb    = ($urandom % 4 != 0) ? {4'b0101, 1'b0, pins} : 8'($urandom);
         ins    = OPS[$urandom % 8] | 8'($urandom % 16);
         if ($urandom % 2 == 0) ins[1:0] = 2'b00;
         sb     = $urandom;
         do_xact(idb, ins, 8'($urandom), 1 + int'($urandom % 6), sb);
      end

      chk("R10 pull never starts with clock high", n_r10, 0);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
   end

endmodule